// File: doc/BRIEF.md
# Burst column address sequencer

This block generates the column addresses for one 8-beat memory burst. A start strobe captures a full column address and an ordering mode. The block then walks the three least significant column bits through eight beats. The upper column bits are replayed unchanged on every beat.

Two orderings are available. In wrapping order, each beat adds one to the offset modulo 8. In interleaved order, the offset on beat k is the start offset XOR k, which keeps all eight beats inside the aligned 8-word block. The beat index moves forward only in cycles where the advance enable is high, so the data path can stall the burst. A new start strobe always wins over the running burst: the old burst is dropped and the new one begins.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low and after its release, with no start strobe yet, valid_o and last_o are 0 and beat_o is 0.
- R2: In the cycle after start_i is sampled high, valid_o is 1, beat_o is 0 and col_o equals the col_i value sampled with the strobe.
- R3: With mode_i = 0 captured (wrapping order), the offset col_o[2:0] on beat k is (start offset + k) mod 8. For example, start 5 gives 5,6,7,0,1,2,3,4.
- R4: With mode_i = 1 captured (interleaved order), the offset col_o[2:0] on beat k is start offset XOR k. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R5: beat_o and col_o move to the next beat only on a clock edge where adv_i is high and valid_o is 1. On any other edge without a start strobe they hold.
- R6: last_o is high exactly when valid_o is 1 and beat_o is 7. An advance on beat 7 without a start strobe ends the burst, so valid_o is 0 on the next cycle.
- R7: Changes on col_i and mode_i while start_i is low have no effect on the running burst.
- R8: A start strobe during an active burst, including one on beat 7, restarts the burst at beat 0 from the new address and mode.
- R9: col_o bits above bit 2 equal the upper bits of col_i captured at the strobe, for every beat of the burst.
- R10: Interleaved order with start offset 0 gives offsets 0 through 7, the same as wrapping order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures col_i and mode_i |
| col_i | input | COL_W | Column address, low 3 bits are the start offset |
| mode_i | input | 1 | 0 = wrapping order, 1 = interleaved order |
| adv_i | input | 1 | Advance to the next beat |
| col_o | output | COL_W | Current column address |
| beat_o | output | 3 | Current beat index |
| valid_o | output | 1 | Burst active |
| last_o | output | 1 | Current beat is beat 7 |

## Verification
The stimulus targets start offsets near the wrap point, such as 5 and 7. If a design added the beat index with a carry out of bit 2, the carry would corrupt the upper bits; if it confused the two orderings, it would give 5,6,7 where 5,4,7 is expected. Strobes land on beat 7 and in the middle of stalls, which catches a design that gives the burst end priority over a restart, or that advances while adv_i is low. The inputs col_i and mode_i change on every cycle without a strobe, so a design that reads them live instead of using its captured copy shows wrong offsets straight away.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    BURST_WRAP = 1'b0,
    BURST_ILV  = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int OFS_W = 3,
  localparam int UP_W = COL_W - OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             mode_i,
  output logic [OFS_W-1:0] ofs0_o,
  output logic [UP_W-1:0]  upper_o,
  output burst_order_e     order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs0_o  <= '0;
      upper_o <= '0;
      order_o <= BURST_WRAP;
    end else if (start_i) begin
      ofs0_o  <= col_i[OFS_W-1:0];
      upper_o <= col_i[COL_W-1:OFS_W];
      order_o <= burst_order_e'(mode_i);
    end
  end

  AST_CTX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> $stable(ofs0_o) && $stable(upper_o) && $stable(order_o)); // R7
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int OFS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [OFS_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam logic [OFS_W-1:0] BEAT_MAX = {OFS_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o  <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      beat_o  <= '0;
      valid_o <= 1'b1;
    end else if (valid_o && adv_i) begin
      if (beat_o == BEAT_MAX) begin
        beat_o  <= '0;
        valid_o <= 1'b0;
      end else begin
        beat_o <= beat_o + 1'b1;
      end
    end
  end

  assign last_o = valid_o && (beat_o == BEAT_MAX);

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o && adv_i && !start_i && !last_o) |-> valid_o && beat_o == $past(beat_o) + 1'b1); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!adv_i && !start_i) |-> $stable(beat_o) && $stable(valid_o)); // R5
  AST_BURST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(last_o && adv_i && !start_i) |-> !valid_o); // R6
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> valid_o && beat_o == '0); // R8
endmodule

// File: rtl/burst_ofs_gen.sv
module burst_ofs_gen
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] ofs0_i,
  input  logic [OFS_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] wrap_ofs, ilv_ofs;

  // adder truncates to OFS_W: wrap inside the block, no carry upward
  assign wrap_ofs = ofs0_i + beat_i;
  assign ilv_ofs  = ofs0_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      BURST_ILV: ofs_o = ilv_ofs;
      default:   ofs_o = wrap_ofs;
    endcase
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9,
  localparam int OFS_W = 3,
  localparam int UP_W  = COL_W - OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             mode_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o,
  output logic [OFS_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [OFS_W-1:0] ofs0, ofs;
  logic [UP_W-1:0]  upper;
  burst_order_e     order;

  burst_ctx_reg #(.COL_W(COL_W), .OFS_W(OFS_W)) u_ctx (
    .clk_i, .rst_ni, .start_i, .col_i, .mode_i,
    .ofs0_o(ofs0), .upper_o(upper), .order_o(order)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk_i, .rst_ni, .start_i, .adv_i,
    .beat_o, .valid_o, .last_o
  );

  burst_ofs_gen #(.OFS_W(OFS_W)) u_ofs (
    .ofs0_i(ofs0), .beat_i(beat_o), .order_i(order), .ofs_o(ofs)
  );

  assign col_o = {upper, ofs};

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> col_o == $past(col_i)); // R2
  AST_WRAP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o && adv_i && !start_i && !last_o) && order == BURST_WRAP
    |-> col_o[OFS_W-1:0] == $past(col_o[OFS_W-1:0]) + 1'b1); // R3
  AST_ILV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o && adv_i && !start_i && !last_o) && order == BURST_ILV
    |-> (col_o[OFS_W-1:0] ^ beat_o) == ($past(col_o[OFS_W-1:0]) ^ $past(beat_o))); // R4
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o && !start_i) && valid_o |-> $stable(col_o[COL_W-1:OFS_W])); // R9
  AST_IDLE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !last_o); // R1
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] col = '0;
  logic             mode = 1'b0;
  logic             adv = 1'b0;
  logic [COL_W-1:0] col_out;
  logic [2:0]       beat;
  logic             valid, last;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  bit         m_valid = 0;
  logic [2:0] m_beat = '0, m_ofs0 = '0;
  bit         m_mode = 0;
  logic [COL_W-4:0] m_up = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_i(col), .mode_i(mode),
    .adv_i(adv), .col_o(col_out), .beat_o(beat), .valid_o(valid), .last_o(last)
  );

  function automatic logic [2:0] exp_ofs(logic [2:0] s, logic [2:0] k, bit ilv);
    return ilv ? (s ^ k) : 3'(s + k);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(valid == m_valid, "R6 valid", valid, m_valid);
    chk(last == (m_valid && m_beat == 3'd7), "R6 last", last, m_valid && m_beat == 3'd7);
    if (m_valid) begin
      chk(beat == m_beat, "R5 beat", beat, m_beat);
      chk(col_out[2:0] == exp_ofs(m_ofs0, m_beat, m_mode), m_mode ? "R4 offset" : "R3 offset",
          col_out[2:0], exp_ofs(m_ofs0, m_beat, m_mode));
      chk(col_out[COL_W-1:3] == m_up, "R9 upper", col_out[COL_W-1:3], m_up);
    end
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(bit s, logic [COL_W-1:0] c, bit m, bit a);
    start = s; col = c; mode = m; adv = a;
    @(posedge clk);
    if (s) begin
      m_valid = 1; m_beat = '0; m_ofs0 = c[2:0]; m_mode = m; m_up = c[COL_W-1:3];
    end else if (m_valid && a) begin
      if (m_beat == 3'd7) m_valid = 0;
      else m_beat = m_beat + 1'b1;
    end
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 2);
    @(negedge clk);
    chk(!valid && !last && beat == 0, "R1 in reset", {valid, last, beat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!valid && !last && beat == 0, "R1 after reset", {valid, last, beat}, 0);

    // R2/R3: wrap order from 5, upper bits 0x2A
    step(1, {6'h2A, 3'd5}, 0, 0);
    chk(col_out == {6'h2A, 3'd5} && beat == 0 && valid, "R2 first beat", col_out, {6'h2A, 3'd5});
    for (int k = 1; k < 8; k++) step(0, 9'($urandom), 1'($urandom), 1); // R7: live inputs churn
    chk(col_out[2:0] == 3'd4 && last, "R3 wrap tail", col_out[2:0], 4);
    step(0, '0, 0, 1);
    chk(!valid, "R6 end", valid, 0);

    // R4: interleaved from 5, with stalls
    step(1, {6'h15, 3'd5}, 1, 1);
    for (int k = 1; k < 8; k++) begin
      step(0, 9'($urandom), 1'($urandom), 0); // R5 stall
      step(0, 9'($urandom), 1'($urandom), 1);
    end
    chk(col_out[2:0] == 3'd2 && beat == 7, "R4 ilv tail", col_out[2:0], 2);
    chk(col_out[8:3] == 6'h15, "R7 upper kept", col_out[8:3], 6'h15);

    // R8: restart on beat 7 with advance high
    step(1, {6'h01, 3'd7}, 0, 1);
    chk(valid && beat == 0 && col_out == {6'h01, 3'd7}, "R8 restart", col_out, {6'h01, 3'd7});
    step(0, '0, 1, 1);
    chk(col_out[2:0] == 3'd0, "R3 wrap 7->0", col_out[2:0], 0);
    step(1, {6'h3F, 3'd3}, 1, 0); // R8 mid-burst restart
    chk(beat == 0 && col_out == {6'h3F, 3'd3}, "R8 mid restart", col_out, {6'h3F, 3'd3});

    // R10: interleaved start 0 follows 0..7
    step(1, {6'h00, 3'd0}, 1, 0);
    for (int k = 0; k < 8; k++) begin
      chk(col_out[2:0] == 3'(k), "R10 ilv zero", col_out[2:0], k);
      step(0, '0, 0, 1);
    end

    // random mix
    for (int i = 0; i < 4000; i++)
      step(($urandom % 12) == 0, 9'($urandom), 1'($urandom), ($urandom % 4) != 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule